// File: doc/BRIEF.md
# Line-Standard Classifier with Pixel-Clock Watchdog

This monitor runs on a free-running reference clock and watches three timing signals: horizontal sync, vertical sync and an activity line that changes level with the incoming pixel clock. It has two jobs. The first is to decide whether the source is a 625-line (50 Hz, PAL) or a 525-line (60 Hz, NTSC) field format. It does this by counting horizontal sync pulses over each complete vertical period, unless a 2-bit select input forces one format. The second job is to emit a one-cycle standby-reset pulse when the pixel clock has been quiet for longer than a programmable number of reference cycles.

Downstream logic uses the resolved format flag and the active line count to size the vertical window: 288 lines for PAL and 240 for NTSC. The nominal field lengths are 312.5 and 262.5 lines, so a threshold of 288 separates them with wide margin. The standby pulse is meant for the power-state logic. It carries no reset of its own into the monitor, so the format decision and any settings held elsewhere are left as they are. All inputs are assumed to be already synchronous to the reference clock.

Top module: `vidstd_mon`

## Requirements
- R1: The select input `std_sel` uses this encoding: 2'b00 forces PAL (`is_pal`=1), 2'b01 forces NTSC (`is_pal`=0), and 2'b1x selects the automatic decision. The output follows a change of `std_sel` in the same cycle.
- R2: `active_lines` is 288 while `is_pal` is 1 and 240 while it is 0.
- R3: In automatic mode, more than 288 rising edges of `hsync` between two consecutive rising edges of `vsync` make the decision PAL, taking effect in the cycle after the second `vsync` edge.
- R4: In automatic mode, fewer than 288 such `hsync` edges make the decision NTSC.
- R5: A count of exactly 288 leaves the previous decision unchanged.
- R6: The decision changes only at a `vsync` rising edge. The first `vsync` edge after reset only starts counting and makes no decision.
- R7: The `hsync` counter saturates at 2^HCNT_W-1, so an overlong period classifies as PAL instead of wrapping to a small count.
- R8: The automatic decision keeps tracking the input while a forced mode is selected, and it appears as soon as automatic mode is selected again.
- R9: `standby_rst` is a pulse of exactly one cycle. It becomes visible TIMEOUT cycles after the clock edge that first samples the last change of `pix_act`, and it does not repeat until `pix_act` changes again.
- R10: Every change of `pix_act`, rising or falling, restarts the quiet timer. Gaps shorter than TIMEOUT never produce a pulse.
- R11: A standby pulse leaves the format decision and `active_lines` unchanged.
- R12: After reset, `standby_rst` is 0 and the automatic decision is NTSC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_act | input | 1 | Level that changes with pixel-clock activity |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| std_sel | input | 2 | Format select: 00 PAL, 01 NTSC, 1x automatic |
| is_pal | output | 1 | Resolved format, 1 = PAL |
| active_lines | output | LINE_W | Active line count for the resolved format |
| standby_rst | output | 1 | One-cycle standby request on pixel-clock loss |

## Verification
The bench targets the boundaries around the threshold. Counts of 287, 288 and 289 are checked: a design with an off-by-one or a non-strict comparison would flip the decision on 288 instead of holding it. An overlong period of 1100 lines is sent with a 10-bit counter; a counter that wraps would see 76 lines and fall back to NTSC. The bench also changes the forced mode in the middle of the stream, to catch a decision that freezes while forced. The watchdog pulse is timed to the exact cycle and checked for a single-cycle width. The bench then checks that a gap just short of the timeout stays silent and that the pulse leaves the format unchanged, which catches a timer that ignores one edge direction or a pulse that clears state.

// File: rtl/vidstd_pkg.sv
package vidstd_pkg;

    typedef enum logic [1:0] {
        SEL_PAL   = 2'b00,
        SEL_NTSC  = 2'b01,
        SEL_AUTO  = 2'b10,
        SEL_AUTO2 = 2'b11
    } std_sel_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_ANY  = 1'b1
    } edge_mode_e;

    typedef struct packed {
        logic seen_vs;   // a vertical edge has opened a counting window
        logic auto_pal;  // current automatic decision
    } cls_state_t;

    localparam int DEF_THRESH     = 288;
    localparam int DEF_PAL_LINES  = 288;
    localparam int DEF_NTSC_LINES = 240;

    function automatic logic resolve_pal(input logic [1:0] sel, input logic auto_pal);
        std_sel_e s;
        s = std_sel_e'(sel);
        case (s)
            SEL_PAL:  return 1'b1;
            SEL_NTSC: return 1'b0;
            default:  return auto_pal;
        endcase
    endfunction

endpackage

// File: rtl/vidstd_edge.sv
module vidstd_edge
    import vidstd_pkg::*;
#(
    parameter int         N    = 1,
    parameter edge_mode_e MODE = EDGE_RISE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] ev
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= d;
    end

    generate
        if (MODE == EDGE_RISE) begin : g_rise
            assign ev = d & ~prev_q;
        end else begin : g_any
            assign ev = d ^ prev_q;
        end
    endgenerate
endmodule

// File: rtl/vidstd_linecls.sv
module vidstd_linecls
    import vidstd_pkg::*;
#(
    parameter int HCNT_W = 10,
    parameter int THRESH = DEF_THRESH
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_rise,
    input  logic vs_rise,
    output logic auto_pal
);
    localparam logic [HCNT_W-1:0] HMAX = {HCNT_W{1'b1}};
    localparam logic [HCNT_W-1:0] THR  = HCNT_W'(THRESH);

    logic [HCNT_W-1:0] line_cnt;
    cls_state_t        st_q;
    logic              next_pal;

    always_comb begin
        next_pal = st_q.auto_pal;
        if (line_cnt > THR)      next_pal = 1'b1;
        else if (line_cnt < THR) next_pal = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt <= '0;
            st_q     <= '{seen_vs: 1'b0, auto_pal: 1'b0};
        end else if (vs_rise) begin
            line_cnt     <= hs_rise ? HCNT_W'(1) : '0;
            st_q.seen_vs <= 1'b1;
            if (st_q.seen_vs) st_q.auto_pal <= next_pal;
        end else if (hs_rise && line_cnt != HMAX) begin
            line_cnt <= line_cnt + 1'b1;
        end
    end

    assign auto_pal = st_q.auto_pal;
endmodule

// File: rtl/vidstd_clkwd.sv
module vidstd_clkwd #(
    parameter int TIMEOUT = 151_200_000
) (
    input  logic clk,
    input  logic rst,
    input  logic pix_edge,
    output logic fire
);
    localparam int           TW    = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT);
    localparam logic [TW-1:0] LAST  = TW'(TIMEOUT - 1);

    logic [TW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            fire     <= 1'b0;
        end else if (pix_edge) begin
            idle_cnt <= '0;
            fire     <= 1'b0;
        end else begin
            fire <= (idle_cnt == LAST);
            if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vidstd_mon.sv
module vidstd_mon
    import vidstd_pkg::*;
#(
    parameter int HCNT_W     = 10,
    parameter int THRESH     = DEF_THRESH,
    parameter int PAL_LINES  = DEF_PAL_LINES,
    parameter int NTSC_LINES = DEF_NTSC_LINES,
    parameter int LINE_W     = 9,
    parameter int TIMEOUT    = 151_200_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_act,
    input  logic              hsync,
    input  logic              vsync,
    input  logic [1:0]        std_sel,
    output logic              is_pal,
    output logic [LINE_W-1:0] active_lines,
    output logic              standby_rst
);
    logic [1:0] sync_rise;
    logic [0:0] pix_chg;
    logic       auto_pal;

    vidstd_edge #(.N(2), .MODE(EDGE_RISE)) u_sync_edge (
        .clk (clk),
        .rst (rst),
        .d   ({vsync, hsync}),
        .ev  (sync_rise)
    );

    vidstd_edge #(.N(1), .MODE(EDGE_ANY)) u_pix_edge (
        .clk (clk),
        .rst (rst),
        .d   (pix_act),
        .ev  (pix_chg)
    );

    vidstd_linecls #(.HCNT_W(HCNT_W), .THRESH(THRESH)) u_cls (
        .clk      (clk),
        .rst      (rst),
        .hs_rise  (sync_rise[0]),
        .vs_rise  (sync_rise[1]),
        .auto_pal (auto_pal)
    );

    vidstd_clkwd #(.TIMEOUT(TIMEOUT)) u_wd (
        .clk      (clk),
        .rst      (rst),
        .pix_edge (pix_chg[0]),
        .fire     (standby_rst)
    );

    assign is_pal       = resolve_pal(std_sel, auto_pal);
    assign active_lines = is_pal ? LINE_W'(PAL_LINES) : LINE_W'(NTSC_LINES);
endmodule

// File: rtl/vidstd_mon_chk.sv
module vidstd_mon_chk (
    input logic       clk,
    input logic       rst,
    input logic       pix_act,
    input logic       vsync,
    input logic [1:0] std_sel,
    input logic       is_pal,
    input logic       standby_rst
);
    a_r1_forced_pal: assert property (@(posedge clk) disable iff (rst)
        (std_sel == 2'b00) |-> is_pal);

    a_r1_forced_ntsc: assert property (@(posedge clk) disable iff (rst)
        (std_sel == 2'b01) |-> !is_pal);

    a_r6_vsync_only: assert property (@(posedge clk) disable iff (rst)
        ($stable(std_sel) && !$stable(is_pal)) |-> ($past(vsync) && !$past(vsync, 2)));

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
        standby_rst |=> !standby_rst);

    a_r10_quiet_before: assert property (@(posedge clk) disable iff (rst)
        standby_rst |-> ($past(pix_act) == $past(pix_act, 2)));
endmodule

bind vidstd_mon vidstd_mon_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pix_act     (pix_act),
    .vsync       (vsync),
    .std_sel     (std_sel),
    .is_pal      (is_pal),
    .standby_rst (standby_rst)
);

// File: tb/vidstd_mon_test.sv
module vidstd_mon_test;
    localparam int TO     = 64;
    localparam int LW     = 9;
    localparam int NVEC   = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pix_act = 1'b0;
    logic          hsync = 1'b0;
    logic          vsync = 1'b0;
    logic [1:0]    std_sel = 2'b10;
    logic          is_pal;
    logic [LW-1:0] active_lines;
    logic          standby_rst;
    logic          pix_run = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    vidstd_mon #(.HCNT_W(10), .TIMEOUT(TO), .LINE_W(LW)) uut (
        .clk          (clk),
        .rst          (rst),
        .pix_act      (pix_act),
        .hsync        (hsync),
        .vsync        (vsync),
        .std_sel      (std_sel),
        .is_pal       (is_pal),
        .active_lines (active_lines),
        .standby_rst  (standby_rst)
    );

    always #2.5 clk = ~clk;

    // pixel activity toggles just after each rising edge while enabled
    initial forever begin
        @(posedge clk);
        #1;
        if (pix_run) pix_act = ~pix_act;
    end

    // fields: select, hsync count, expected PAL flag
    localparam logic [13:0] VEC [NVEC] = '{
        {2'b10, 11'd300, 1'b1},   // R3
        {2'b10, 11'd262, 1'b0},   // R4
        {2'b10, 11'd288, 1'b0},   // R5 hold NTSC
        {2'b10, 11'd289, 1'b1},   // R3 boundary
        {2'b10, 11'd288, 1'b1},   // R5 hold PAL
        {2'b10, 11'd287, 1'b0},   // R4 boundary
        {2'b00, 11'd250, 1'b1},   // R1 forced PAL
        {2'b01, 11'd312, 1'b0},   // R1 forced NTSC
        {2'b11, 11'd100, 1'b0},   // R1 auto alias
        {2'b11, 11'd313, 1'b1}    // R3
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hs_pulse();
        @(negedge clk) hsync = 1'b1;
        @(negedge clk) hsync = 1'b0;
    endtask

    task automatic vs_pulse();
        @(negedge clk) vsync = 1'b1;
        @(negedge clk) vsync = 1'b0;
    endtask

    task automatic frame(input int nh);
        for (int i = 0; i < nh; i++) hs_pulse();
        vs_pulse();
    endtask

    task automatic chk_std(input bit exp_pal, input string req);
        chk(is_pal == exp_pal, req, int'(is_pal), int'(exp_pal));
        chk(active_lines == (exp_pal ? LW'(288) : LW'(240)), "R2",
            int'(active_lines), exp_pal ? 288 : 240);
    endtask

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int first_hi;
        int n_hi;
        bit pal_before;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk(standby_rst == 1'b0, "R12", int'(standby_rst), 0);
        chk_std(1'b0, "R12");

        // R6: first vsync opens the window only
        frame(300);
        chk_std(1'b0, "R6");
        // R6: no change from hsync alone mid-period
        for (int i = 0; i < 295; i++) hs_pulse();
        chk_std(1'b0, "R6");
        vs_pulse();
        chk_std(1'b1, "R3");

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            std_sel = VEC[v][13:12];
            frame(int'(VEC[v][11:1]));
            chk_std(VEC[v][0], $sformatf("R3/R4/R5/R1 vec%0d", v));
        end

        // R8: auto keeps tracking under forced NTSC
        std_sel = 2'b01;
        frame(100);
        frame(310);
        chk_std(1'b0, "R1");
        std_sel = 2'b10;
        #1;
        chk_std(1'b1, "R8");
        std_sel = 2'b00;
        frame(120);
        std_sel = 2'b10;
        #1;
        chk_std(1'b0, "R8");

        // R7: saturating counter on an overlong period
        frame(1100);
        chk_std(1'b1, "R7");

        // R10: gap just under timeout stays silent
        @(negedge clk) pix_run = 1'b0;
        n_hi = 0;
        for (int k = 0; k < TO - 4; k++) begin
            @(negedge clk);
            if (standby_rst) n_hi++;
        end
        pix_run = 1'b1;
        for (int k = 0; k < 2 * TO; k++) begin
            @(negedge clk);
            if (standby_rst) n_hi++;
        end
        chk(n_hi == 0, "R10", n_hi, 0);

        // R9: exact timing and width of the pulse; R11 no side effect
        pal_before = is_pal;
        @(negedge clk) pix_run = 1'b0;
        first_hi = -1;
        n_hi = 0;
        for (int k = 0; k < 4 * TO; k++) begin
            @(negedge clk);
            if (standby_rst) begin
                n_hi++;
                if (first_hi < 0) first_hi = k;
            end
        end
        chk(first_hi == TO, "R9", first_hi, TO);
        chk(n_hi == 1, "R9", n_hi, 1);
        chk_std(pal_before, "R11");

        // R10: a single falling change restarts the timer and re-arms the pulse
        @(negedge clk) pix_act = ~pix_act;
        first_hi = -1;
        n_hi = 0;
        for (int k = 0; k < 2 * TO; k++) begin
            @(negedge clk);
            if (standby_rst) begin
                n_hi++;
                if (first_hi < 0) first_hi = k;
            end
        end
        chk(first_hi == TO, "R10", first_hi, TO);
        chk(n_hi == 1, "R9", n_hi, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule